// File: doc/BRIEF.md
# Column-Wise Block Check-Word Generator

This block produces the protection words for a memory block of 256 words of 32 bits. The first 247 positions carry data and the last nine carry check words. The code does not run across the bits of one word. It runs down each of the 32 bit columns, so every column of the block is its own modified Hamming codeword of length 256. All columns share the same nine parity equations, so one 32-bit XOR per equation covers all columns at once.

Data words arrive on a valid/ready stream, one per handshake, each tagged with its block position. When the last data word (position 246) has been taken, the block stops taking input. It then offers the nine check words in order on an output valid/ready stream, each tagged with its check number, for storage at positions 247 to 255. Three of the check words are complemented before output, so that a column stuck at all-zero or all-one cannot look like a valid codeword. A start pulse abandons any block in progress and prepares for a new one.

Top module: `blk_chk_gen`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `idx_err` is 0, and the block expects data position 0.
- R2: Every 9-bit value with an odd number of ones and at least three ones is a data column, and these are given to positions 0 to 246 in ascending numeric order. Check word i, before any inversion, is the XOR of all accepted data words whose column has bit i set.
- R3: Check words 1, 5 and 6 are output bitwise complemented. The other six check words are output as computed.
- R4: Once position 246 is accepted, `out_valid` rises and the nine check words are offered with `out_sel` = 0, 1, … 8 in that order, one per handshake. While `out_valid` is 1 and `out_ready` is 0, `out_sel` and `out_word` hold steady.
- R5: `in_ready` is 0 while check words are offered and after the ninth handshake, until the next start pulse. After the ninth handshake, `out_valid` is 0.
- R6: An accepted word whose `in_idx` is not the next expected position (skipped, repeated or above 246) sets `idx_err` from the following cycle and has no effect on any check word or on the expected position. `idx_err` stays set until start.
- R7: A `start` pulse clears all accumulators, the expected position and `idx_err`, and from the next cycle `in_ready` is 1 and `out_valid` is 0.
- R8: Bit j of every check word depends only on bit j of the data words, so that each bit column is encoded on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new block, which discards any block in progress |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Block can take a data word |
| in_idx | input | 8 | Block position of the offered word |
| in_data | input | 32 | Data word |
| out_valid | output | 1 | Check word offered |
| out_ready | input | 1 | Consumer takes the check word |
| out_sel | output | 4 | Number of the offered check word (0 to 8) |
| out_word | output | 32 | Check word, with the inversion already applied |
| idx_err | output | 1 | Sticky flag: a word with an unexpected position was seen |

## Verification
The bench uses the default parameters: 32-bit words, nine check words and 256-word blocks. Only this size reaches the irregular gaps in the column sequence, for example where weight-one values such as 0x100 must be skipped. It also exercises the last column, 0x1FF, at position 246. Blocks in which a single bit is set at a chosen position and column expose the mapping from position to column and the independence of the columns directly. Random blocks, skipped and repeated positions, a position above 246, and a block abandoned by start cover the accumulate, reject and clear paths under random input gaps and output stalls.

// File: rtl/blk_chk_pkg.sv
// Package: shared types for the column-wise block check generator.
// Assumes nothing beyond the parameters given to the top module.
package blk_chk_pkg;

    // Top-level phase of one block.
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,   // taking data words
        ST_EMIT    = 2'd1,   // offering check words
        ST_DONE    = 2'd2    // block finished, waiting for start
    } phase_t;

endpackage

// File: rtl/blk_col_seq.sv
// Module: blk_col_seq
// Produces the code column for the next expected data position. The column
// starts at the smallest odd-weight value with weight of at least three, and
// each advance moves to the next larger value of that kind. Assumes that
// successive qualifying values are never more than LOOKAHEAD apart, which
// holds for the nine-bit code (the widest gap, around 0x100, is five).
module blk_col_seq #(
    parameter int CHK_N     = 9,
    parameter int LOOKAHEAD = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [CHK_N-1:0] col
);

    localparam logic [CHK_N-1:0] FIRST_COL = CHK_N'(7);

    logic [CHK_N-1:0] nxt_col;
    logic [CHK_N-1:0] cand [LOOKAHEAD];
    logic [LOOKAHEAD-1:0] qual;

    // Candidate values col+1 .. col+LOOKAHEAD and their eligibility.
    for (genvar k = 0; k < LOOKAHEAD; k++) begin : g_cand
        assign cand[k] = col + CHK_N'(k + 1);
        assign qual[k] = (^cand[k]) && ($countones(cand[k]) >= 3);
    end

    // Pick the nearest eligible candidate, or hold if none.
    always_comb begin
        nxt_col = col;
        for (int k = LOOKAHEAD - 1; k >= 0; k--) begin
            if (qual[k]) nxt_col = cand[k];
        end
    end

    // Column register: restarts on clear, steps on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) col <= FIRST_COL;
        else if (advance)    col <= nxt_col;
    end

endmodule

// File: rtl/blk_chk_acc.sv
// Module: blk_chk_acc
// Bank of one accumulator per check word. On each enabled cycle, every
// accumulator whose bit is set in the current column is XORed with the whole
// data word, so that all bit columns are encoded in parallel. Assumes that
// the caller enables it only for in-order data words.
module blk_chk_acc #(
    parameter int DATA_W = 32,
    parameter int CHK_N  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic [CHK_N-1:0]  col,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] acc [CHK_N]
);

    for (genvar i = 0; i < CHK_N; i++) begin : g_acc
        // Accumulator i: cleared at block start, folds in words covering check i.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)   acc[i] <= '0;
            else if (en && col[i]) acc[i] <= acc[i] ^ data;
        end
    end

endmodule

// File: rtl/blk_chk_emit.sv
// Module: blk_chk_emit
// Steps through the check words in ascending order, one per step, and
// applies the storage inversion mask as each word is presented. Assumes
// that step is asserted only while a word is being offered.
module blk_chk_emit #(
    parameter int               DATA_W   = 32,
    parameter int               CHK_N    = 9,
    parameter logic [CHK_N-1:0] INV_MASK = CHK_N'(9'h062)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     step,
    input  logic [DATA_W-1:0]        acc [CHK_N],
    output logic [$clog2(CHK_N)-1:0] sel,
    output logic                     last,
    output logic [DATA_W-1:0]        word
);

    localparam int SEL_W = $clog2(CHK_N);

    assign last = (sel == SEL_W'(CHK_N - 1));

    // Check-word counter: restarts on clear, moves on each taken word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  sel <= '0;
        else if (step && !last) sel <= sel + 1'b1;
    end

    // Output mux with per-word complement.
    always_comb begin
        word = '0;
        for (int i = 0; i < CHK_N; i++) begin
            if (sel == SEL_W'(i)) word = acc[i] ^ {DATA_W{INV_MASK[i]}};
        end
    end

endmodule

// File: rtl/blk_chk_gen.sv
// Module: blk_chk_gen (top)
// Computes the check words of one memory block whose bit columns are each
// protected by a modified Hamming code. Takes the data words in position
// order, rejects words with an unexpected position, and then offers the
// check words in order. Assumes that the consumer stores check word i at
// position DATA_N + i.
module blk_chk_gen
    import blk_chk_pkg::*;
#(
    parameter int               DATA_W    = 32,
    parameter int               CHK_N     = 9,
    parameter int               BLK_WORDS = 256,
    parameter logic [CHK_N-1:0] INV_MASK  = CHK_N'(9'h062),
    parameter int               IDX_W     = $clog2(BLK_WORDS),
    parameter int               SEL_W     = $clog2(CHK_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SEL_W-1:0]  out_sel,
    output logic [DATA_W-1:0] out_word,
    output logic              idx_err
);

    localparam int DATA_N = BLK_WORDS - CHK_N;

    phase_t            phase;
    logic [IDX_W-1:0]  exp_idx;
    logic [CHK_N-1:0]  col;
    logic [DATA_W-1:0] acc [CHK_N];
    logic              in_hs, good_hs, bad_hs, out_hs, last_sel;

    assign in_ready  = (phase == ST_COLLECT);
    assign out_valid = (phase == ST_EMIT);
    assign in_hs     = in_valid && in_ready;
    assign good_hs   = in_hs && (in_idx == exp_idx) && !start;
    assign bad_hs    = in_hs && (in_idx != exp_idx) && !start;
    assign out_hs    = out_valid && out_ready && !start;

    blk_col_seq #(
        .CHK_N     (CHK_N),
        .LOOKAHEAD (8)
    ) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .advance (good_hs),
        .col     (col)
    );

    blk_chk_acc #(
        .DATA_W (DATA_W),
        .CHK_N  (CHK_N)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .en    (good_hs),
        .col   (col),
        .data  (in_data),
        .acc   (acc)
    );

    blk_chk_emit #(
        .DATA_W   (DATA_W),
        .CHK_N    (CHK_N),
        .INV_MASK (INV_MASK)
    ) u_emit (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .step  (out_hs),
        .acc   (acc),
        .sel   (out_sel),
        .last  (last_sel),
        .word  (out_word)
    );

    // Block phase, expected position and sticky position error.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            phase   <= ST_COLLECT;
            exp_idx <= '0;
            idx_err <= 1'b0;
        end else begin
            if (bad_hs) idx_err <= 1'b1;
            case (phase)
                ST_COLLECT: if (good_hs) begin
                    exp_idx <= exp_idx + 1'b1;
                    if (exp_idx == IDX_W'(DATA_N - 1)) phase <= ST_EMIT;
                end
                ST_EMIT:    if (out_hs && last_sel) phase <= ST_DONE;
                default:    phase <= ST_DONE;
            endcase
        end
    end

endmodule

// File: rtl/blk_chk_gen_chk.sv
// Module: blk_chk_gen_chk
// Protocol checker for blk_chk_gen, attached by bind. It sees only the
// ports of the top module.
module blk_chk_gen_chk #(
    parameter int CHK_N  = 9,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [SEL_W-1:0]  out_sel,
    input logic [DATA_W-1:0] out_word,
    input logic              idx_err
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid && !idx_err));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=>
        (out_valid && $stable(out_sel) && $stable(out_word)));

    // R4
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sel < SEL_W'(CHK_N)));

    // R4
    sel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !start && out_sel != SEL_W'(CHK_N - 1)) |=>
        (out_valid && out_sel == $past(out_sel) + 1'b1));

    // R5
    emit_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R5
    emit_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !start && out_sel == SEL_W'(CHK_N - 1)) |=>
        (!out_valid && !in_ready));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_err && !start) |=> idx_err);

    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (in_ready && !out_valid && !idx_err));

endmodule

bind blk_chk_gen blk_chk_gen_chk #(
    .CHK_N  (CHK_N),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sel   (out_sel),
    .out_word  (out_word),
    .idx_err   (idx_err)
);

// File: tb/blk_chk_gen_test.sv
module blk_chk_gen_test;

    localparam int DW = 32;
    localparam int NC = 9;
    localparam int ND = 247;
    localparam logic [8:0] INV = 9'h062;   // R3: checks 1, 5, 6 complemented

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_idx = '0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [3:0]  out_sel;
    logic [31:0] out_word;
    logic        idx_err;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit ended = 0;

    logic [31:0] blk [ND];
    logic [8:0]  col_tab [ND];

    blk_chk_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_sel(out_sel),
        .out_word(out_word), .idx_err(idx_err)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%h expected=%h", cycles, 150000);
                finish_run();
            end
        end
    end

    // R2: data columns, odd weight of at least three, ascending.
    function automatic void build_tab();
        int n = 0;
        for (int v = 0; v < 512; v++) begin
            logic [8:0] vv = 9'(v);
            if (($countones(vv) % 2 == 1) && ($countones(vv) >= 3)) begin
                col_tab[n] = vv;
                n++;
            end
        end
    endfunction

    function automatic logic [31:0] exp_chk(input int i);
        logic [31:0] r = '0;
        for (int p = 0; p < ND; p++) if (col_tab[p][i]) r ^= blk[p];
        if (INV[i]) r = ~r;
        return r;
    endfunction

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(in_ready && !out_valid && !idx_err, "R7 start clears",
              {29'd0, in_ready, out_valid, idx_err}, 32'h4);
    endtask

    task automatic send(input logic [7:0] idx, input logic [31:0] d);
        int gap = $urandom % 4;
        for (int g = 0; g < gap; g++) @(negedge clk);
        in_valid = 1'b1;
        in_idx = idx;
        in_data = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_block(input bit inject);
        for (int p = 0; p < ND; p++) begin
            if (inject && (p == 50 || p == 100 || p == 200)) begin
                logic [7:0] bidx = (p == 50) ? 8'(p + 2) : (p == 100) ? 8'(p - 1) : 8'd250;
                check(idx_err == (p != 50), "R6 flag before bad word",
                      {31'd0, idx_err}, {31'd0, p != 50});
                send(bidx, $urandom);
                check(idx_err == 1'b1, "R6 bad index flagged", {31'd0, idx_err}, 32'd1);
            end
            send(8'(p), blk[p]);
        end
    endtask

    task automatic collect(input string req);
        int k = 0;
        while (k < NC) begin
            out_ready = ($urandom % 3) != 0;
            if (out_valid) begin
                check(out_sel == 4'(k), "R4 order", {28'd0, out_sel}, k);
                check(out_word == exp_chk(k), req, out_word, exp_chk(k));
                check(!in_ready, "R5 input blocked", {31'd0, in_ready}, 32'd0);
                if (out_ready) k++;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(!out_valid && !in_ready, "R5 idle after nine",
              {30'd0, out_valid, in_ready}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        build_tab();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid && !idx_err, "R1 reset state",
              {29'd0, in_ready, out_valid, idx_err}, 32'h4);

        // All-zero block, straight after reset: R3 shows in checks 1, 5, 6.
        for (int p = 0; p < ND; p++) blk[p] = '0;
        send_block(0);
        collect("R3 zero block");

        // All-ones block.
        pulse_start();
        for (int p = 0; p < ND; p++) blk[p] = '1;
        send_block(0);
        collect("R3 ones block");

        // Single-bit blocks: mapping of position to column, and column independence.
        foreach (col_tab[q]) begin end
        for (int t = 0; t < 6; t++) begin
            int pos = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 119 :
                      (t == 3) ? 120 : (t == 4) ? 121 : 246;
            int bitj = $urandom % DW;
            pulse_start();
            for (int p = 0; p < ND; p++) blk[p] = '0;
            blk[pos] = 32'd1 << bitj;
            send_block(0);
            collect((t % 2 == 0) ? "R2 single word" : "R8 single column");
        end

        // Random blocks.
        for (int t = 0; t < 4; t++) begin
            pulse_start();
            for (int p = 0; p < ND; p++) blk[p] = $urandom;
            send_block(0);
            collect("R2 random block");
        end

        // Bad indices: skipped, repeated, out of range.
        pulse_start();
        for (int p = 0; p < ND; p++) blk[p] = $urandom;
        send_block(1);
        collect("R6 bad words ignored");
        check(idx_err == 1'b1, "R6 flag sticky", {31'd0, idx_err}, 32'd1);

        // Block abandoned part-way by start.
        pulse_start();
        for (int p = 0; p < 30; p++) send(8'(p), $urandom);
        check(in_ready && !out_valid, "R7 mid-block", {30'd0, in_ready, out_valid}, 32'h2);
        pulse_start();
        for (int p = 0; p < ND; p++) blk[p] = $urandom;
        send_block(0);
        collect("R7 fresh block after abort");

        finish_run();
    end

endmodule